// File: doc/BRIEF.md
# Hall Edge Speed Meter

This block turns the three raw rotor-position sensor lines of a brushless motor into a shaft speed. The lines are brought into the clock domain and filtered against glitches. Every accepted change to a legal position code is reported as a one-cycle pulse. The time since the previous such change is measured in microseconds from a divided-down time base. That interval is then converted to revolutions per minute, with the number of magnet pole pairs given on an input port.

Three sensors produce six position changes per electrical revolution. The speed is therefore 60,000,000 divided by the product of the interval in microseconds, six and the pole-pair count. A bit-serial divider computes the quotient and announces it with a valid pulse. If no change arrives before the interval counter runs out, the reported speed drops to zero. A controller reads `rpm` on `rpm_valid` and can use `hall_state` and `hall_edge` directly for commutation timing.

Top module: `hall_speed_meter`

## Requirements
- R1: The sensor lines pass through SYNC_STAGES flip-flops. A new code is taken into `hall_state` only once it has been present on the synchronized lines for `filt_len`+1 consecutive clocks, where a `filt_len` of 0 behaves as 1. A shorter pulse leaves `hall_state` and `hall_edge` untouched.
- R2: `hall_edge` is high for exactly one clock for each accepted change to a legal code. It rises in the same cycle that `hall_state` takes the new code.
- R3: The codes 3'b000 and 3'b111 are illegal. When one is accepted, `hall_state` shows it and `hall_invalid` goes high. No `hall_edge` is raised and no interval is captured, so the timing continues from the last legal edge. `hall_invalid` clears when the next legal code is accepted.
- R4: The interval between consecutive `hall_edge` pulses is counted in microseconds, with one tick every TICK_DIV clocks. An interval of N×TICK_DIV clocks yields exactly N. `period_us` changes only in the cycle after a `hall_edge`. The first edge after reset only starts the timing.
- R5: `rpm` = floor(60,000,000 / (period_us × 6 × pole_pairs)), clamped to 2^RPM_W−1. It is produced by a sequential divide and marked by a one-clock `rpm_valid`. For example, 714 us with 7 pole pairs gives 2000.
- R6: A zero divisor, from `pole_pairs` = 0 or an interval of 0, gives `rpm` = 2^RPM_W−1.
- R7: The interval counter saturates at 2^PER_W−1. One clock after it reaches that value, `rpm` reads 0. The edge that follows captures `period_us` = 2^PER_W−1 and raises `rpm_valid` with `rpm` = 0.
- R8: During reset, `hall_state`, `hall_edge`, `period_us`, `rpm` and `rpm_valid` are 0 and `hall_invalid` is 1.
- R9: Between updates `rpm` holds its value. It changes only together with `rpm_valid` or when it is forced to 0 by R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall_in | input | 3 | Raw sensor lines, asynchronous |
| filt_len | input | FLT_W (4) | Required stability length in clocks, minus one |
| pole_pairs | input | PP_W (4) | Motor pole-pair count |
| hall_state | output | 3 | Filtered sensor code |
| hall_edge | output | 1 | One-clock pulse per accepted legal change |
| hall_invalid | output | 1 | Filtered code is 000 or 111 |
| period_us | output | PER_W (16) | Last captured edge interval in microseconds |
| rpm | output | RPM_W (16) | Shaft speed |
| rpm_valid | output | 1 | One-clock pulse when `rpm` is updated by a measurement |

## Verification
The checker accepts any value on `hall_in` at any time. It does assume that `pole_pairs` and `filt_len` stay steady while a measurement is under way, and that Hall changes are spaced further apart than the divide latency, so that no capture restarts a divide that is still running. The bench drives every input on falling edges and changes `pole_pairs` only after the previous `rpm_valid`. Legal Hall changes are spaced at least 200 clocks apart, except in the deliberate glitch cases, where no speed value is checked.

// File: rtl/hall_speed_pkg.sv
package hall_speed_pkg;

   typedef logic [2:0] hall_code_t;

   // microseconds in one minute: numerator of the speed conversion
   localparam int unsigned US_PER_MIN = 60_000_000;

   function automatic logic hall_code_ok(input hall_code_t c);
      return (c != 3'b000) && (c != 3'b111);
   endfunction

endpackage

// File: rtl/hall_glitch_filter.sv
module hall_glitch_filter
   import hall_speed_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FLT_W       = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       hall_raw,
   input  logic [FLT_W-1:0] filt_len,
   output hall_code_t       state_o,
   output logic             edge_o,
   output logic             invalid_o
);

   hall_code_t       sync_q [SYNC_STAGES];
   hall_code_t       prev_q;
   hall_code_t       state_q;
   logic [FLT_W-1:0] stab_q;
   logic [FLT_W-1:0] eff_len;
   logic             edge_q;
   logic             inval_q;
   logic             accept;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[g] <= '0;
            else        sync_q[g] <= hall_raw;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[g] <= '0;
            else        sync_q[g] <= sync_q[g-1];
         end
      end
   end

   assign eff_len = (filt_len == '0) ? FLT_W'(1) : filt_len;
   assign accept  = (prev_q != state_q) && (stab_q >= eff_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         stab_q  <= '0;
         state_q <= '0;
         edge_q  <= 1'b0;
         inval_q <= 1'b1;
      end else begin
         prev_q <= sync_q[SYNC_STAGES-1];
         if (sync_q[SYNC_STAGES-1] == prev_q) begin
            if (stab_q != '1) stab_q <= stab_q + 1'b1;
         end else begin
            stab_q <= '0;
         end
         edge_q <= 1'b0;
         if (accept) begin
            state_q <= prev_q;
            edge_q  <= hall_code_ok(prev_q);
            inval_q <= !hall_code_ok(prev_q);
         end
      end
   end

   assign state_o   = state_q;
   assign edge_o    = edge_q;
   assign invalid_o = inval_q;

endmodule

// File: rtl/hall_period_timer.sv
module hall_period_timer #(
   parameter int unsigned TICK_DIV = 100,
   parameter int unsigned PER_W    = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_i,
   output logic [PER_W-1:0] period_o,
   output logic             cap_o,
   output logic             sat_o
);

   localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   logic             tick;
   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] cnt_nx;
   logic [PER_W-1:0] period_q;
   logic             cap_q;
   logic             armed_q;

   if (TICK_DIV == 1) begin : g_tick_every
      assign tick = 1'b1;
   end else begin : g_tick_div
      logic [PRE_W-1:0] presc_q;
      assign tick = (presc_q == PRE_W'(TICK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      presc_q <= '0;
         else if (edge_i) presc_q <= '0;
         else if (tick)   presc_q <= '0;
         else             presc_q <= presc_q + 1'b1;
      end
   end

   assign sat_o  = (cnt_q == '1);
   assign cnt_nx = (tick && !sat_o) ? cnt_q + 1'b1 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         period_q <= '0;
         cap_q    <= 1'b0;
         armed_q  <= 1'b0;
      end else begin
         cap_q <= 1'b0;
         if (edge_i) begin
            if (armed_q) begin
               period_q <= cnt_nx;
               cap_q    <= 1'b1;
            end
            armed_q <= 1'b1;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_nx;
         end
      end
   end

   assign period_o = period_q;
   assign cap_o    = cap_q;

endmodule

// File: rtl/hall_rpm_divider.sv
module hall_rpm_divider #(
   parameter int unsigned NUMER = 60_000_000,
   parameter int unsigned NUM_W = 26,
   parameter int unsigned DEN_W = 23
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [DEN_W-1:0] den_i,
   output logic [NUM_W-1:0] quo_o,
   output logic             done_o
);

   localparam int unsigned CW = $clog2(NUM_W + 1);

   logic [NUM_W-1:0] num_q;
   logic [NUM_W-1:0] quo_q;
   logic [DEN_W-1:0] rem_q;
   logic [DEN_W-1:0] den_q;
   logic [CW-1:0]    cnt_q;
   logic             busy_q;
   logic             done_q;
   logic [DEN_W:0]   trial;
   logic [DEN_W-1:0] diff;
   logic             ge;

   assign trial = {rem_q, num_q[NUM_W-1]};
   assign ge    = (trial >= {1'b0, den_q});
   assign diff  = trial[DEN_W-1:0] - den_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num_q  <= '0;
         quo_q  <= '0;
         rem_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            if (den_i == '0) begin
               quo_q  <= '1;
               done_q <= 1'b1;
               busy_q <= 1'b0;
            end else begin
               num_q  <= NUM_W'(NUMER);
               quo_q  <= '0;
               rem_q  <= '0;
               den_q  <= den_i;
               cnt_q  <= CW'(NUM_W);
               busy_q <= 1'b1;
            end
         end else if (busy_q) begin
            rem_q <= ge ? diff : trial[DEN_W-1:0];
            quo_q <= {quo_q[NUM_W-2:0], ge};
            num_q <= {num_q[NUM_W-2:0], 1'b0};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign quo_o  = quo_q;
   assign done_o = done_q;

endmodule

// File: rtl/hall_speed_meter.sv
module hall_speed_meter
   import hall_speed_pkg::*;
#(
   parameter int unsigned TICK_DIV    = 100,
   parameter int unsigned PER_W       = 16,
   parameter int unsigned PP_W        = 4,
   parameter int unsigned FLT_W       = 4,
   parameter int unsigned RPM_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       hall_in,
   input  logic [FLT_W-1:0] filt_len,
   input  logic [PP_W-1:0]  pole_pairs,
   output logic [2:0]       hall_state,
   output logic             hall_edge,
   output logic             hall_invalid,
   output logic [PER_W-1:0] period_us,
   output logic [RPM_W-1:0] rpm,
   output logic             rpm_valid
);

   localparam int unsigned NUM_W = $clog2(US_PER_MIN + 1);
   localparam int unsigned DEN_W = PER_W + PP_W + 3;

   if (TICK_DIV < 1) begin : g_chk_tick
      $error("TICK_DIV must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PER_W < 8 || PER_W > 24) begin : g_chk_per
      $error("PER_W must lie in 8..24");
   end
   if (RPM_W >= NUM_W || RPM_W < 8) begin : g_chk_rpm
      $error("RPM_W must lie in 8..NUM_W-1");
   end

   hall_code_t       state;
   logic             edge_pls;
   logic             invalid;
   logic [PER_W-1:0] period;
   logic             cap;
   logic             cnt_sat;
   logic             cap_max;
   logic [DEN_W-1:0] den;
   logic [NUM_W-1:0] quo;
   logic             div_done;
   logic [RPM_W-1:0] rpm_q;
   logic             rpm_vld_q;

   hall_glitch_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FLT_W       (FLT_W)
   ) u_filter (
      .clk       (clk),
      .rst_n     (rst_n),
      .hall_raw  (hall_in),
      .filt_len  (filt_len),
      .state_o   (state),
      .edge_o    (edge_pls),
      .invalid_o (invalid)
   );

   hall_period_timer #(
      .TICK_DIV (TICK_DIV),
      .PER_W    (PER_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_i   (edge_pls),
      .period_o (period),
      .cap_o    (cap),
      .sat_o    (cnt_sat)
   );

   assign cap_max = (period == '1);
   assign den     = DEN_W'(period) * DEN_W'(6) * DEN_W'(pole_pairs);

   hall_rpm_divider #(
      .NUMER (US_PER_MIN),
      .NUM_W (NUM_W),
      .DEN_W (DEN_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (cap && !cap_max),
      .den_i   (den),
      .quo_o   (quo),
      .done_o  (div_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rpm_q     <= '0;
         rpm_vld_q <= 1'b0;
      end else begin
         rpm_vld_q <= 1'b0;
         if (cap && cap_max) begin
            rpm_q     <= '0;
            rpm_vld_q <= 1'b1;
         end else if (div_done) begin
            rpm_q     <= (|quo[NUM_W-1:RPM_W]) ? '1 : quo[RPM_W-1:0];
            rpm_vld_q <= 1'b1;
         end
         if (cnt_sat) rpm_q <= '0;
      end
   end

   assign hall_state   = state;
   assign hall_edge    = edge_pls;
   assign hall_invalid = invalid;
   assign period_us    = period;
   assign rpm          = rpm_q;
   assign rpm_valid    = rpm_vld_q;

endmodule

// File: rtl/hall_speed_meter_chk.sv
module hall_speed_meter_chk #(
   parameter int unsigned PER_W = 16,
   parameter int unsigned RPM_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       hall_state,
   input logic             hall_edge,
   input logic             hall_invalid,
   input logic [PER_W-1:0] period_us,
   input logic [RPM_W-1:0] rpm,
   input logic             rpm_valid,
   input logic             cnt_sat
);

   AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      hall_edge |=> !hall_edge); // R2

   AST_STATE_MOVE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(hall_state) && !hall_invalid) |-> hall_edge); // R2

   AST_EDGE_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      hall_edge |-> (!hall_invalid && hall_state != 3'b000 && hall_state != 3'b111)); // R3

   AST_PERIOD_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(period_us) |-> $past(hall_edge)); // R4

   AST_RPM_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rpm_valid |=> !rpm_valid); // R5

   AST_SAT_ZERO_RPM: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_sat |=> (rpm == '0)); // R7

   AST_RPM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rpm) |-> (rpm_valid || rpm == '0)); // R9

endmodule

bind hall_speed_meter hall_speed_meter_chk #(
   .PER_W (PER_W),
   .RPM_W (RPM_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hall_state   (hall_state),
   .hall_edge    (hall_edge),
   .hall_invalid (hall_invalid),
   .period_us    (period_us),
   .rpm          (rpm),
   .rpm_valid    (rpm_valid),
   .cnt_sat      (cnt_sat)
);

// File: tb/test_hall_speed_meter.sv
`timescale 1ns/1ps
module test_hall_speed_meter;

   localparam int TICK  = 4;
   localparam int PER_W = 12;
   localparam int MAXP  = (1 << PER_W) - 1;

   typedef struct packed {
      logic [3:0]  pp;
      logic [11:0] per;
      logic [15:0] exp_rpm;
   } vec_t;

   // pole pairs, interval in us, expected rpm
   localparam vec_t VEC [10] = '{
      '{4'd7,  12'd714,  16'd2000},
      '{4'd7,  12'd1430, 16'd999},
      '{4'd7,  12'd143,  16'd9990},
      '{4'd1,  12'd1000, 16'd10000},
      '{4'd2,  12'd500,  16'd10000},
      '{4'd4,  12'd2500, 16'd1000},
      '{4'd15, 12'd100,  16'd6666},
      '{4'd1,  12'd50,   16'd65535},
      '{4'd0,  12'd300,  16'd65535},
      '{4'd7,  12'd200,  16'd7142}
   };

   localparam logic [2:0] HSEQ [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  hall_in = 3'b001;
   logic [3:0]  filt_len = 4'd4;
   logic [3:0]  pole_pairs = 4'd7;
   logic [2:0]  hall_state;
   logic        hall_edge;
   logic        hall_invalid;
   logic [11:0] period_us;
   logic [15:0] rpm;
   logic        rpm_valid;

   int checks = 0;
   int fails = 0;
   int hidx = 0;
   int elapsed = 0;
   int edges = 0;
   logic got_valid;
   logic [11:0] snap;

   always #2 clk = ~clk;

   hall_speed_meter #(
      .TICK_DIV (TICK), .PER_W (PER_W), .PP_W (4), .FLT_W (4), .RPM_W (16), .SYNC_STAGES (2)
   ) i_hall_speed_meter (
      .clk (clk), .rst_n (rst_n), .hall_in (hall_in), .filt_len (filt_len),
      .pole_pairs (pole_pairs), .hall_state (hall_state), .hall_edge (hall_edge),
      .hall_invalid (hall_invalid), .period_us (period_us), .rpm (rpm), .rpm_valid (rpm_valid)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step_hall();
      hidx = (hidx + 1) % 6;
      hall_in = HSEQ[hidx];
   endtask

   task automatic wait_valid();
      got_valid = 1'b0;
      while (!got_valid && elapsed < 200) begin
         @(negedge clk);
         elapsed++;
         if (rpm_valid) got_valid = 1'b1;
      end
   endtask

   task automatic timed_step(input int per);
      repeat (per * TICK - elapsed) @(negedge clk);
      step_hall();
      elapsed = 0;
      wait_valid();
   endtask

   task automatic count_edges(input int n);
      edges = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (hall_edge) edges++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      // reset values
      repeat (5) @(negedge clk);
      check("R8", "hall_state", hall_state, 0);
      check("R8", "hall_edge", hall_edge, 0);
      check("R3", "hall_invalid in reset", hall_invalid, 1);
      check("R8", "period_us", period_us, 0);
      check("R8", "rpm", rpm, 0);
      check("R8", "rpm_valid", rpm_valid, 0);
      rst_n = 1'b1;

      // arming edge from the code present at reset
      count_edges(30);
      check("R2", "arming edge count", edges, 1);
      check("R1", "accepted code", hall_state, 3'b001);
      check("R3", "invalid cleared", hall_invalid, 0);
      got_valid = 1'b0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (rpm_valid) got_valid = 1'b1;
      end
      check("R4", "no capture on first edge", period_us, 0);
      check("R4", "no rpm on first edge", got_valid, 0);

      // reference edge for the table
      step_hall();
      elapsed = 0;
      wait_valid();

      // table of intervals and expected speeds
      for (int i = 0; i < 10; i++) begin
         pole_pairs = VEC[i].pp;
         timed_step(int'(VEC[i].per));
         check("R5", $sformatf("vec %0d rpm_valid seen", i), got_valid, 1);
         check("R4", $sformatf("vec %0d period_us", i), period_us, int'(VEC[i].per));
         if (VEC[i].pp == 0)
            check("R6", $sformatf("vec %0d zero divisor rpm", i), rpm, int'(VEC[i].exp_rpm));
         else
            check("R5", $sformatf("vec %0d rpm", i), rpm, int'(VEC[i].exp_rpm));
      end

      // glitch of filt_len clocks is rejected
      snap = 12'(HSEQ[hidx]);
      hall_in = HSEQ[(hidx + 1) % 6];
      repeat (4) @(negedge clk);
      hall_in = HSEQ[hidx];
      count_edges(30);
      check("R1", "short glitch edges", edges, 0);
      check("R1", "state after glitch", hall_state, int'(snap));

      // a pulse of filt_len+1 clocks is accepted, and so is the return
      hall_in = HSEQ[(hidx + 1) % 6];
      repeat (5) @(negedge clk);
      hall_in = HSEQ[hidx];
      count_edges(40);
      check("R1", "long pulse edges", edges, 2);
      check("R1", "state after pulse", hall_state, int'(snap));

      // illegal code in the middle of an interval is skipped by timing
      pole_pairs = 4'd7;
      repeat (300) @(negedge clk);
      step_hall();
      elapsed = 0;
      wait_valid();
      snap = period_us;
      repeat (100 * TICK - elapsed) @(negedge clk);
      hall_in = 3'b111;
      count_edges(20);
      check("R3", "edges on illegal code", edges, 0);
      check("R3", "hall_invalid", hall_invalid, 1);
      check("R3", "hall_state shows illegal", hall_state, 7);
      check("R3", "period_us untouched", period_us, int'(snap));
      repeat (100 * TICK - 20) @(negedge clk);
      step_hall();
      elapsed = 0;
      wait_valid();
      check("R3", "invalid cleared on legal code", hall_invalid, 0);
      check("R4", "interval spans illegal code", period_us, 200);
      check("R5", "rpm across illegal code", rpm, 7142);

      // rpm holds between updates
      repeat (1000) @(negedge clk);
      check("R9", "rpm held", rpm, 7142);

      // counter saturation
      repeat (MAXP * TICK + 100) @(negedge clk);
      check("R7", "rpm forced to zero", rpm, 0);
      step_hall();
      elapsed = 0;
      wait_valid();
      check("R7", "valid after saturation", got_valid, 1);
      check("R7", "saturated period", period_us, MAXP);
      check("R7", "rpm after saturation", rpm, 0);

      // recovery
      timed_step(714);
      check("R5", "recovery rpm", rpm, 2000);
      check("R4", "recovery period", period_us, 714);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule